// File: doc/BRIEF.md
# ALU Functional Self-Test Sequencer

This block runs a fixed functional test on an 8-bit ALU and checks every result itself. A start pulse launches the run. The sequencer first writes a known value into the ALU operand registers. It then walks two nested loops. The outer loop takes each operation code in turn, and the inner loop takes each operand pair from a built-in table. Every step has three cycles: load the operands, apply the operation, and sample the ALU result.

Each sampled result is compared with a value the block computes itself from the current opcode and operands. A mismatch raises a fail flag that stays set, and adds one to a failure counter that stops at its maximum. Four of the operand pairs are arranged so that every bit position of the two operands sees 00, 01, 10 and 11. This exercises the operation-select and bit-slice logic of the ALU in a handful of patterns. The remaining pairs target carry chains and all-zero or all-one data.

Top module: `alu_selftest_seq`

## Requirements
- R1: While reset is held and afterwards until a start, done_o, fail_o, alu_we_o and alu_go_o are 0 and err_cnt_o is 0.
- R2: A start pulse accepted in idle is followed, in the next cycle, by one operand-load cycle (alu_we_o=1, alu_go_o=0) with both alu_a_o and alu_b_o equal to 0x00. This happens before any operation is applied.
- R3: Each test step is exactly three cycles. In the first, alu_we_o=1 and alu_go_o=0 with the pair on alu_a_o/alu_b_o. In the second, alu_go_o=1 and alu_we_o=0 with the opcode on alu_op_o. In the third, both are 0 and alu_res_i is sampled.
- R4: Opcodes run in the outer loop in ascending order 0 to 4. Operand pairs 0 to 7 run in the inner loop, in table order, once per opcode.
- R5: The operand table, as (A,B) in hex, is 0:(CC,AA) 1:(99,55) 2:(33,AA) 3:(66,55) 4:(55,AA) 5:(FF,01) 6:(00,FF) 7:(01,FF). Across pairs 0 to 3, every bit position of A and B takes all four combinations 00, 01, 10 and 11.
- R6: The expected result is a copy of A for opcode 0, A+B mod 256 for 1, A-B mod 256 for 2, A AND B for 3 and A XOR B for 4.
- R7: Any mismatch sets fail_o, which stays set through the end of the run and in idle until the next accepted start.
- R8: err_cnt_o counts mismatching steps and saturates at 15 (all ones of CNT_W=4 bits).
- R9: done_o is high for exactly one cycle, 122 cycles after the start edge (1 load cycle, 40 steps of 3 cycles, then done). The block then returns to idle with alu_we_o and alu_go_o low.
- R10: A start pulse while a run is in progress is ignored. The run keeps its timing and done_o pulses only once.
- R11: An accepted start clears fail_o and err_cnt_o, so a clean run that follows a failing one ends with both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a test run (accepted in idle only) |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| alu_a_o | output | 8 | First operand toward the ALU |
| alu_b_o | output | 8 | Second operand toward the ALU |
| alu_we_o | output | 1 | Load operands into the ALU operand registers |
| alu_op_o | output | 3 | ALU operation code |
| alu_go_o | output | 1 | Apply the operation; result is valid the next cycle |
| alu_res_i | input | 8 | ALU result |
| fail_o | output | 1 | Sticky failure flag |
| err_cnt_o | output | CNT_W (4) | Saturating count of failing steps |

## Verification
The hardest state to reach from the ports is a saturated failure counter. That needs at least sixteen wrong results in one run, which a single faulty operation cannot produce. The bench ALU model takes a fault mode that inverts every result, which gives forty mismatches. A clean run follows at once to show the clear on start. The other fault modes corrupt one operation each, such as a lost carry, swapped subtraction operands, or OR in place of AND or XOR. Their hand-counted mismatch totals confirm that every opcode and pair is really compared. One run injects a start pulse mid-sequence to show it is ignored.

// File: rtl/alu_st_pkg.sv
package alu_st_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned OP_W      = 3;
    localparam int unsigned NUM_OPS   = 5;
    localparam int unsigned NUM_PAIRS = 8;
    localparam int unsigned PAIR_W    = $clog2(NUM_PAIRS);

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_COPY = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_XOR  = 3'd4
    } alu_op_e;

    typedef struct packed {
        word_t a;
        word_t b;
    } opnd_pair_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_LOAD,
        ST_EXEC,
        ST_READ,
        ST_DONE
    } seq_state_e;

    // Repeat a 4-bit pattern across the data word (LSB of pattern at bit 0).
    function automatic word_t nib_fill(input logic [3:0] nib);
        word_t w;
        for (int i = 0; i < DATA_W; i++) begin
            w[i] = nib[2'(i % 4)];
        end
        return w;
    endfunction

    // Operand table; pairs 0..3 give every bit position all four A/B combinations.
    function automatic opnd_pair_t pair_at(input logic [PAIR_W-1:0] idx);
        opnd_pair_t p;
        case (idx)
            3'd0:    p = '{a: nib_fill(4'b1100), b: nib_fill(4'b1010)};
            3'd1:    p = '{a: nib_fill(4'b1001), b: nib_fill(4'b0101)};
            3'd2:    p = '{a: nib_fill(4'b0011), b: nib_fill(4'b1010)};
            3'd3:    p = '{a: nib_fill(4'b0110), b: nib_fill(4'b0101)};
            3'd4:    p = '{a: nib_fill(4'b0101), b: nib_fill(4'b1010)};
            3'd5:    p = '{a: '1,                b: word_t'(1)};
            3'd6:    p = '{a: '0,                b: '1};
            default: p = '{a: word_t'(1),        b: '1};
        endcase
        return p;
    endfunction

    function automatic word_t op_eval(input alu_op_e op, input word_t a, input word_t b);
        word_t r;
        case (op)
            OP_COPY: r = a;
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_AND:  r = a & b;
            OP_XOR:  r = a ^ b;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_st_ref.sv
module alu_st_ref
    import alu_st_pkg::*;
(
    input  alu_op_e op_i,
    input  word_t   a_i,
    input  word_t   b_i,
    output word_t   exp_o
);

    word_t lane [NUM_OPS];

    // One reference lane per operation, selected by the current opcode.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
        assign lane[g] = op_eval(alu_op_e'(OP_W'(g)), a_i, b_i);
    end

    always_comb begin
        exp_o = '0;
        if (int'(op_i) < int'(NUM_OPS)) begin
            exp_o = lane[op_i];
        end
    end

endmodule

// File: rtl/alu_st_ctrl.sv
module alu_st_ctrl
    import alu_st_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    output logic       clr_o,
    output logic       we_o,
    output logic       go_o,
    output logic       rd_o,
    output logic       done_o,
    output alu_op_e    op_o,
    output opnd_pair_t pair_o
);

    localparam logic [OP_W-1:0]   LAST_OP   = OP_W'(NUM_OPS - 1);
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);

    seq_state_e        st_q, st_d;
    logic [OP_W-1:0]   op_q;
    logic [PAIR_W-1:0] pix_q;
    logic              last_step;

    assign last_step = (op_q == LAST_OP) && (pix_q == LAST_PAIR);
    assign clr_o     = (st_q == ST_IDLE) && start_i;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start_i) st_d = ST_INIT;
            ST_INIT: st_d = ST_LOAD;
            ST_LOAD: st_d = ST_EXEC;
            ST_EXEC: st_d = ST_READ;
            ST_READ: st_d = last_step ? ST_DONE : ST_LOAD;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            op_q  <= '0;
            pix_q <= '0;
        end else begin
            st_q <= st_d;
            if (clr_o) begin
                op_q  <= '0;
                pix_q <= '0;
            end else if (st_q == ST_READ) begin
                if (pix_q == LAST_PAIR) begin
                    pix_q <= '0;
                    op_q  <= op_q + OP_W'(1);
                end else begin
                    pix_q <= pix_q + PAIR_W'(1);
                end
            end
        end
    end

    always_comb begin
        we_o   = (st_q == ST_INIT) || (st_q == ST_LOAD);
        go_o   = (st_q == ST_EXEC);
        rd_o   = (st_q == ST_READ);
        done_o = (st_q == ST_DONE);
        op_o   = alu_op_e'(op_q);
        pair_o = '0;
        if ((st_q == ST_LOAD) || (st_q == ST_EXEC) || (st_q == ST_READ)) begin
            pair_o = pair_at(pix_q);
        end
    end

    // R3
    go_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        go_o |-> $past(we_o));

    // R4
    op_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        go_o |-> (int'(op_o) < int'(NUM_OPS)));

    // R2
    init_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_o |=> (we_o && !go_o && pair_o == '0));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/alu_st_chk.sv
module alu_st_chk
    import alu_st_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             rd_i,
    input  word_t            exp_i,
    input  word_t            res_i,
    output logic             fail_o,
    output logic [CNT_W-1:0] err_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             fail_q;
    logic [CNT_W-1:0] err_q;
    logic             miss;

    assign miss = rd_i && (res_i != exp_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            fail_q <= 1'b0;
            err_q  <= '0;
        end else if (miss) begin
            fail_q <= 1'b1;
            if (err_q != CNT_MAX) begin
                err_q <= err_q + CNT_W'(1);
            end
        end
    end

    assign fail_o = fail_q;
    assign err_o  = err_q;

    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_q && !clr_i) |=> fail_q);

    // R8
    err_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (err_q >= $past(err_q)));

    // R8
    err_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q == CNT_MAX && !clr_i) |=> (err_q == CNT_MAX));

endmodule

// File: rtl/alu_selftest_seq.sv
module alu_selftest_seq
    import alu_st_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             done_o,
    output logic [7:0]       alu_a_o,
    output logic [7:0]       alu_b_o,
    output logic             alu_we_o,
    output logic [2:0]       alu_op_o,
    output logic             alu_go_o,
    input  logic [7:0]       alu_res_i,
    output logic             fail_o,
    output logic [CNT_W-1:0] err_cnt_o
);

    logic       clr;
    logic       rd;
    alu_op_e    op;
    opnd_pair_t pair;
    word_t      expv;

    alu_st_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .clr_o   (clr),
        .we_o    (alu_we_o),
        .go_o    (alu_go_o),
        .rd_o    (rd),
        .done_o  (done_o),
        .op_o    (op),
        .pair_o  (pair)
    );

    alu_st_ref u_ref (
        .op_i  (op),
        .a_i   (pair.a),
        .b_i   (pair.b),
        .exp_o (expv)
    );

    alu_st_chk #(.CNT_W(CNT_W)) u_chk (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .rd_i   (rd),
        .exp_i  (expv),
        .res_i  (alu_res_i),
        .fail_o (fail_o),
        .err_o  (err_cnt_o)
    );

    assign alu_a_o  = pair.a;
    assign alu_b_o  = pair.b;
    assign alu_op_o = op;

endmodule

// File: tb/alu_selftest_seq_tb_top.sv
`timescale 1ns/1ps
module alu_selftest_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       done, we, go, fail;
    logic [7:0] a, b, res;
    logic [2:0] op;
    logic [3:0] errc;

    int fault = 0;
    int n_run = 0;
    int n_fail = 0;
    logic [3:0] pe [8];

    localparam logic [15:0] PAIRS [8] = '{16'hCCAA, 16'h9955, 16'h33AA, 16'h6655,
                                          16'h55AA, 16'hFF01, 16'h00FF, 16'h01FF};
    localparam int N_VEC = 7;
    localparam int VEC_MODE [N_VEC] = '{2, 0, 1, 3, 4, 5, 6};
    localparam int VEC_ERRS [N_VEC] = '{15, 0, 8, 8, 8, 6, 6};

    always #2 clk = ~clk;

    alu_selftest_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start), .done_o(done),
        .alu_a_o(a), .alu_b_o(b), .alu_we_o(we), .alu_op_o(op), .alu_go_o(go),
        .alu_res_i(res), .fail_o(fail), .err_cnt_o(errc)
    );

    // Behavioural ALU with injectable faults.
    function automatic logic [7:0] tb_alu(input logic [2:0] o, input logic [7:0] x,
                                          input logic [7:0] y, input int f);
        logic [7:0] r;
        case (o)
            3'd0:    r = (f == 3) ? y : x;
            3'd1:    r = (f == 5) ? (x ^ y) : (x + y);
            3'd2:    r = (f == 4) ? (y - x) : (x - y);
            3'd3:    r = (f == 1) ? (x | y) : (x & y);
            3'd4:    r = (f == 6) ? (x | y) : (x ^ y);
            default: r = 8'h00;
        endcase
        if (f == 2) r = ~r;
        return r;
    endfunction

    logic [7:0] ra, rb;
    always_ff @(posedge clk) begin
        if (rst) begin
            ra  <= '0;
            rb  <= '0;
            res <= '0;
        end else begin
            if (we) begin
                ra <= a;
                rb <= b;
            end
            if (go) res <= tb_alu(op, ra, rb, fault);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input int fm, input int mid, output int dcyc,
                       output bit sok, output int bad_at);
        fault = fm;
        sok = 1'b1;
        dcyc = -1;
        bad_at = 0;
        for (int k = 0; k < 8; k++) pe[k] = 4'h0;
        @(negedge clk);
        start = 1'b1;
        for (int c = 1; c <= 400; c++) begin
            @(negedge clk);
            if (c == 1) start = 1'b0;
            if (mid != 0 && c == mid) start = 1'b1;
            if (mid != 0 && c == mid + 1) start = 1'b0;
            if (done) begin
                dcyc = c;
                break;
            end
            begin
                bit ew, eg, ok;
                logic [7:0] ea, eb;
                logic [2:0] eo;
                int s, step, ph;
                ok = 1'b1;
                if (c == 1) begin
                    ok = we && !go && a == 8'h00 && b == 8'h00;
                end else begin
                    s = c - 2;
                    step = s / 3;
                    ph = s % 3;
                    ea = PAIRS[step % 8][15:8];
                    eb = PAIRS[step % 8][7:0];
                    eo = 3'(step / 8);
                    if (step >= 40) ok = 1'b0;
                    else if (ph == 0) begin
                        ew = 1'b1; eg = 1'b0;
                        ok = (we == ew) && (go == eg) && a == ea && b == eb;
                        if (step < 4) begin
                            for (int k = 0; k < 8; k++) pe[k][{a[k], b[k]}] = 1'b1;
                        end
                    end else if (ph == 1) begin
                        ok = !we && go && op == eo;
                    end else begin
                        ok = !we && !go;
                    end
                end
                if (!ok && sok) begin
                    sok = 1'b0;
                    bad_at = c;
                end
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int dcyc, bad_at;
        bit sok;
        logic f0;
        logic [3:0] e0;
        // R1 during and after reset
        repeat (4) @(negedge clk);
        check(!done && !fail && !we && !go && errc == 0, "R1", "outputs in reset",
              {done, fail, we, go}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !fail && !we && !go && errc == 0, "R1", "outputs idle after reset",
              {done, fail, we, go}, 0);

        for (int v = 0; v < N_VEC; v++) begin
            run(VEC_MODE[v], (v == 3) ? 50 : 0, dcyc, sok, bad_at);
            // R2 R3 R4 R5: operand/opcode order per cycle
            check(sok, "R2/R3/R4/R5", "port sequence first bad cycle", bad_at, 0);
            // R9 done timing (R10 for the run with a mid-run start)
            check(dcyc == 122, (v == 3) ? "R10" : "R9", "done cycle", dcyc, 122);
            @(negedge clk);
            check(!done && !we && !go, "R9", "done single cycle then idle", {done, we, go}, 0);
            // R6 R8 R11 mismatch count
            check(int'(errc) == VEC_ERRS[v], (v == 1) ? "R11" : "R8", "error count",
                  errc, VEC_ERRS[v]);
            check(fail == (VEC_ERRS[v] != 0), "R7", "fail flag", fail, VEC_ERRS[v] != 0);
            if (v == 0) begin
                for (int k = 0; k < 8; k++) begin
                    check(pe[k] == 4'hF, "R5", "bit combinations seen", pe[k], 15);
                end
            end
            f0 = fail;
            e0 = errc;
            repeat (5) @(negedge clk);
            check(fail == f0 && errc == e0, "R7", "flag held in idle", {fail, errc}, {f0, e0});
            if (v == 1) begin
                check(!fail, "R6", "clean ALU gives pass", fail, 0);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule